// File: doc/BRIEF.md
# DRAM Page-Hit Traffic Generator

This block produces an endless stream of memory request descriptors for loading a DRAM controller in a controlled way. Each descriptor carries a byte address, a read/write flag and a fixed burst size. A valid/ready handshake passes one descriptor per accepted cycle. The requests come in runs. A run is a fixed number of bursts that walk successive columns of one page in one bank. The run length sets how many row hits occur back to back. The number of banks in use sets how much bank parallelism the controller can exploit. Varying the two settings covers a two-dimensional space of DRAM timing stress.

At the start of each run the block draws a random aligned address inside a configured window, a bank index, a start column and a direction. Four seeded LFSR lanes supply these values. The bank and column values are then written into the address according to one of two field layouts. Later requests in the run step the column field by one. Burst size, columns per page and total bank count are powers of two, fixed by parameters. A byte counter totals the traffic accepted on the handshake. The model covers one channel and one rank.

Top module: `pagehit_gen`

## Requirements
- R1: While `rst_n` is low, `req_valid` is 0 and `byte_count` is 0. `req_valid` is 1 from the first rising edge after reset is released and stays 1 from then on.
- R2: The direction is fixed for a whole run. `cfg_read_pct` = 0 gives only writes (`req_is_read` = 0). `cfg_read_pct` >= 100 gives only reads. A value between those gives a mix of read and write runs.
- R3: Every request address has its low `BURST_BITS` bits at zero. In the first request of a run, the bits above both the bank field and the column field equal those bits of some address in [`cfg_start_addr`, `cfg_end_addr`).
- R4: The bank field of every request is below `cfg_banks_used`. A value of 0 is treated as 1.
- R5: The column field of the first request of a run is at most 2^`COL_BITS` − `cfg_run_len`, so the whole run fits in one page.
- R6: A run is exactly `cfg_run_len` requests long. Within a run, each request has the column field one above the previous one. The bank field, the bits above the fields and the direction stay unchanged.
- R7: With `cfg_map_sel` = 1, the column field is at bits [`BURST_BITS` +: `COL_BITS`] and the bank field is directly above it.
- R8: With `cfg_map_sel` = 0, the bank field is at bits [`BURST_BITS` +: `BANK_BITS`] and the column field is directly above it.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_addr` and `req_is_read` stay stable and `byte_count` does not change.
- R10: Each cycle with `req_valid` and `req_ready` both 1 adds 2^`BURST_BITS` to `byte_count` on the next edge.
- R11: `req_bytes` always equals 2^`BURST_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_addr | input | ADDR_W | Lowest address of the draw window (burst aligned) |
| cfg_end_addr | input | ADDR_W | One past the highest address of the draw window |
| cfg_run_len | input | COL_BITS+1 | Bursts per run, 1 to 2^COL_BITS |
| cfg_banks_used | input | BANK_BITS+1 | Number of banks the runs may target |
| cfg_read_pct | input | 7 | Read share of runs in percent |
| cfg_map_sel | input | 1 | 1: column field low; 0: bank field low |
| req_valid | output | 1 | Request descriptor available |
| req_ready | input | 1 | Consumer accepts the descriptor this cycle |
| req_addr | output | ADDR_W | Request byte address |
| req_is_read | output | 1 | 1 for read, 0 for write |
| req_bytes | output | BURST_BITS+1 | Burst size in bytes |
| byte_count | output | BYTE_W | Total bytes accepted since reset |

## Verification
The bound checker watches the properties that hold on every cycle. These are handshake stability under backpressure, the byte counter step, burst alignment, the bank bound, the start-column bound, the column-plus-one step with bank and direction held inside a run, the forced direction at 0 and 100 percent, and `req_valid` staying high once raised. Other behaviours need whole scenarios. These are the two field layouts told apart under different bank counts, runs of length 1 and of a full page, the high address bits staying inside the draw window, and a middle read percentage producing both directions. The bench's directed tasks cover these by grouping the accepted stream into runs of the configured length.

// File: rtl/pgen_pkg.sv
// Shared definitions for the page-hit traffic generator.
// Assumes: a 32-bit Galois LFSR per random lane; lane seeds derive from one base.
package pgen_pkg;

    typedef enum logic {
        MAP_BANK_LOW = 1'b0,
        MAP_COL_LOW  = 1'b1
    } map_e;

    localparam int          NUM_DRAWS   = 4;
    localparam logic [31:0] LFSR_MASK   = 32'h8020_0003;
    localparam logic [31:0] SEED_SPREAD = 32'h9E37_79B9;

    // Derive a distinct nonzero seed for one random lane.
    function automatic logic [31:0] lane_seed(input logic [31:0] base, input int lane);
        logic [31:0] s;
        s = base ^ (SEED_SPREAD * 32'(lane + 1));
        if (s == 32'h0) s = 32'h1;
        return s;
    endfunction

endpackage

// File: rtl/pgen_lfsr.sv
// One pseudo-random lane: a 32-bit Galois LFSR that advances when step is high.
// Assumes: SEED is nonzero. The mask has its top bit set, so the state never reaches zero.
module pgen_lfsr
    import pgen_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [31:0] value
);

    logic [31:0] state_q;

    // Reload the seed on reset and shift once per step request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {1'b0, state_q[31:1]} ^ (state_q[0] ? LFSR_MASK : 32'h0);
        end
    end

    assign value = state_q;

endmodule

// File: rtl/pgen_run_draw.sv
// Builds the first request of a run from four random lanes: the window address,
// the bank index, the start column and the direction, placed by the field layout.
// Assumes: start address burst aligned, 1 <= run_len <= 2^COL_BITS (other values
// pin the column to 0), BURST_BITS >= 1 and BANK_BITS >= 1.
module pgen_run_draw
    import pgen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BURST_BITS = 5,
    parameter int COL_BITS   = 5,
    parameter int BANK_BITS  = 3
) (
    input  logic [NUM_DRAWS-1:0][31:0] rnd,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic [ADDR_W-1:0]          end_addr,
    input  logic [COL_BITS:0]          run_len,
    input  logic [BANK_BITS:0]         banks_used,
    input  logic [6:0]                 read_pct,
    input  map_e                       map_sel,
    output logic [ADDR_W-1:0]          first_addr,
    output logic                       first_is_read
);

    localparam int COLS     = 1 << COL_BITS;
    localparam int COL_LO_A = BURST_BITS;              // column field, column-low layout
    localparam int BNK_LO_A = BURST_BITS + COL_BITS;   // bank field, column-low layout
    localparam int BNK_LO_B = BURST_BITS;              // bank field, bank-low layout
    localparam int COL_LO_B = BURST_BITS + BANK_BITS;  // column field, bank-low layout

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] base;
    logic [31:0]       bank_div;
    logic [31:0]       col_div;
    logic [31:0]       pct_draw;

    // Reduce each lane into its range and assemble the run's first address.
    always_comb begin
        span   = end_addr - start_addr;
        offset = (span == '0) ? '0 : (ADDR_W'(rnd[0]) % span);
        base   = start_addr + offset;
        base[BURST_BITS-1:0] = '0;

        bank_div = (banks_used == '0) ? 32'd1 : 32'(banks_used);
        col_div  = (run_len == '0 || run_len > (COL_BITS+1)'(COLS)) ? 32'd1
                 : 32'(COLS) - 32'(run_len) + 32'd1;
        pct_draw = rnd[3] % 32'd101;

        first_addr = base;
        if (map_sel == MAP_COL_LOW) begin
            first_addr[COL_LO_A +: COL_BITS]  = COL_BITS'(rnd[2] % col_div);
            first_addr[BNK_LO_A +: BANK_BITS] = BANK_BITS'(rnd[1] % bank_div);
        end else begin
            first_addr[BNK_LO_B +: BANK_BITS] = BANK_BITS'(rnd[1] % bank_div);
            first_addr[COL_LO_B +: COL_BITS]  = COL_BITS'(rnd[2] % col_div);
        end

        if (read_pct == 7'd0)        first_is_read = 1'b0;
        else if (read_pct >= 7'd100) first_is_read = 1'b1;
        else                         first_is_read = pct_draw < 32'(read_pct);
    end

endmodule

// File: rtl/pgen_col_step.sv
// Computes the next address inside a run: the same page and bank, one column on.
// Column-low layout adds one burst. Bank-low layout recovers the column from
// the bits above the bank field, adds one and writes it back.
// Assumes: the run never walks past the page end (guaranteed by the draw).
module pgen_col_step
    import pgen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BURST_BITS = 5,
    parameter int COL_BITS   = 5,
    parameter int BANK_BITS  = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  map_e              map_sel,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int                COL_LO_B    = BURST_BITS + BANK_BITS;
    localparam logic [ADDR_W-1:0] BURST_BYTES = ADDR_W'(1) << BURST_BITS;

    logic [COL_BITS-1:0] cur_col;

    // Advance the column according to the active layout.
    always_comb begin
        cur_col   = cur_addr[COL_LO_B +: COL_BITS];
        next_addr = cur_addr;
        if (map_sel == MAP_COL_LOW) begin
            next_addr = cur_addr + BURST_BYTES;
        end else begin
            next_addr[COL_LO_B +: COL_BITS] = cur_col + COL_BITS'(1);
        end
    end

endmodule

// File: rtl/pagehit_gen.sv
// Page-hit traffic generator top. It holds one registered request, starts a new
// random run when the current run is used up, steps the column otherwise, and
// counts accepted bytes.
// Assumes: configuration changes only while rst_n is low; synchronous active-low reset.
module pagehit_gen
    import pgen_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          BURST_BITS = 5,
    parameter int          COL_BITS   = 5,
    parameter int          BANK_BITS  = 3,
    parameter int          BYTE_W     = 32,
    parameter logic [31:0] SEED       = 32'h1ACE_B00C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cfg_start_addr,
    input  logic [ADDR_W-1:0]     cfg_end_addr,
    input  logic [COL_BITS:0]     cfg_run_len,
    input  logic [BANK_BITS:0]    cfg_banks_used,
    input  logic [6:0]            cfg_read_pct,
    input  logic                  cfg_map_sel,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [ADDR_W-1:0]     req_addr,
    output logic                  req_is_read,
    output logic [BURST_BITS:0]   req_bytes,
    output logic [BYTE_W-1:0]     byte_count
);

    localparam int              RUN_W       = COL_BITS + 1;
    localparam logic [BYTE_W-1:0] BURST_BYTES = BYTE_W'(1) << BURST_BITS;

    logic [NUM_DRAWS-1:0][31:0] rnd;
    map_e                       map_mode;
    logic                       valid_q;
    logic [ADDR_W-1:0]          addr_q;
    logic                       rd_q;
    logic [RUN_W-1:0]           remain_q;
    logic [BYTE_W-1:0]          bytes_q;
    logic [RUN_W-1:0]           run_last;
    logic                       accept;
    logic                       start_run;
    logic                       step_run;
    logic [ADDR_W-1:0]          draw_addr;
    logic                       draw_rd;
    logic [ADDR_W-1:0]          step_addr;

    assign map_mode  = map_e'(cfg_map_sel);
    assign run_last  = (cfg_run_len == '0) ? '0 : cfg_run_len - RUN_W'(1);
    assign accept    = valid_q & req_ready;
    assign start_run = !valid_q | (accept & (remain_q == '0));
    assign step_run  = accept & (remain_q != '0);

    // One LFSR lane per random draw, each with its own seed.
    for (genvar g = 0; g < NUM_DRAWS; g++) begin : g_lane
        pgen_lfsr #(
            .SEED (lane_seed(SEED, g))
        ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (start_run),
            .value (rnd[g])
        );
    end

    pgen_run_draw #(
        .ADDR_W     (ADDR_W),
        .BURST_BITS (BURST_BITS),
        .COL_BITS   (COL_BITS),
        .BANK_BITS  (BANK_BITS)
    ) u_draw (
        .rnd           (rnd),
        .start_addr    (cfg_start_addr),
        .end_addr      (cfg_end_addr),
        .run_len       (cfg_run_len),
        .banks_used    (cfg_banks_used),
        .read_pct      (cfg_read_pct),
        .map_sel       (map_mode),
        .first_addr    (draw_addr),
        .first_is_read (draw_rd)
    );

    pgen_col_step #(
        .ADDR_W     (ADDR_W),
        .BURST_BITS (BURST_BITS),
        .COL_BITS   (COL_BITS),
        .BANK_BITS  (BANK_BITS)
    ) u_step (
        .cur_addr  (addr_q),
        .map_sel   (map_mode),
        .next_addr (step_addr)
    );

    // Hold the presented request; load a new run or step the column on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            addr_q   <= '0;
            rd_q     <= 1'b0;
            remain_q <= '0;
        end else if (start_run) begin
            valid_q  <= 1'b1;
            addr_q   <= draw_addr;
            rd_q     <= draw_rd;
            remain_q <= run_last;
        end else if (step_run) begin
            addr_q   <= step_addr;
            remain_q <= remain_q - RUN_W'(1);
        end
    end

    // Total bytes handed over on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)      bytes_q <= '0;
        else if (accept) bytes_q <= bytes_q + BURST_BYTES;
    end

    assign req_valid   = valid_q;
    assign req_addr    = addr_q;
    assign req_is_read = rd_q;
    assign req_bytes   = (BURST_BITS+1)'(1) << BURST_BITS;
    assign byte_count  = bytes_q;

endmodule

// File: rtl/pgen_checker.sv
// Protocol and run-structure checker for pagehit_gen, attached with bind.
// Assumes: configuration is held steady outside reset.
module pgen_checker #(
    parameter int ADDR_W     = 32,
    parameter int BURST_BITS = 5,
    parameter int COL_BITS   = 5,
    parameter int BANK_BITS  = 3,
    parameter int BYTE_W     = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                req_is_read,
    input logic [BYTE_W-1:0]   byte_count,
    input logic [COL_BITS:0]   cfg_run_len,
    input logic [BANK_BITS:0]  cfg_banks_used,
    input logic [6:0]          cfg_read_pct,
    input logic                cfg_map_sel,
    input logic [COL_BITS:0]   remain_q
);

    localparam int                COLS        = 1 << COL_BITS;
    localparam logic [BYTE_W-1:0] BURST_BYTES = BYTE_W'(1) << BURST_BITS;

    logic [COL_BITS-1:0]  col_now;
    logic [BANK_BITS-1:0] bank_now;
    logic [BANK_BITS:0]   bank_lim;
    logic [COL_BITS:0]    len_eff;
    logic [COL_BITS:0]    col_lim;
    logic [COL_BITS:0]    run_last;

    // Pull the column and bank fields out of the address for the active layout.
    always_comb begin
        if (cfg_map_sel) begin
            col_now  = req_addr[BURST_BITS +: COL_BITS];
            bank_now = req_addr[BURST_BITS + COL_BITS +: BANK_BITS];
        end else begin
            bank_now = req_addr[BURST_BITS +: BANK_BITS];
            col_now  = req_addr[BURST_BITS + BANK_BITS +: COL_BITS];
        end
        bank_lim = (cfg_banks_used == '0) ? (BANK_BITS+1)'(1) : cfg_banks_used;
        len_eff  = (cfg_run_len == '0) ? (COL_BITS+1)'(1) : cfg_run_len;
        col_lim  = (COL_BITS+1)'(COLS) - len_eff;
        run_last = len_eff - (COL_BITS+1)'(1);
    end

    assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> req_valid);

    assert_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_read_pct == 7'd0) |-> !req_is_read);

    assert_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_read_pct >= 7'd100) |-> req_is_read);

    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[BURST_BITS-1:0] == '0));

    assert_bank_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, bank_now} < bank_lim));

    assert_start_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && remain_q == run_last) |-> ({1'b0, col_now} <= col_lim));

    assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && remain_q != '0) |=>
            (col_now == $past(col_now) + COL_BITS'(1)) && $stable(bank_now) && $stable(req_is_read));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_is_read)
                                      && $stable(byte_count));

    assert_byte_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (byte_count == $past(byte_count) + BURST_BYTES));

endmodule

bind pagehit_gen pgen_checker #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS),
    .COL_BITS   (COL_BITS),
    .BANK_BITS  (BANK_BITS),
    .BYTE_W     (BYTE_W)
) u_pgen_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_is_read    (req_is_read),
    .byte_count     (byte_count),
    .cfg_run_len    (cfg_run_len),
    .cfg_banks_used (cfg_banks_used),
    .cfg_read_pct   (cfg_read_pct),
    .cfg_map_sel    (cfg_map_sel),
    .remain_q       (remain_q)
);

// File: tb/tb_pagehit_gen.sv
`timescale 1ns/1ps
// Directed bench for pagehit_gen: one task per scenario, each checking its own results.
module tb_pagehit_gen;

    localparam int ADDR_W     = 32;
    localparam int BURST_BITS = 5;
    localparam int COL_BITS   = 5;
    localparam int BANK_BITS  = 3;
    localparam int BYTE_W     = 32;
    localparam int COLS       = 1 << COL_BITS;
    localparam int BURST      = 1 << BURST_BITS;
    localparam int HI_SHIFT   = BURST_BITS + COL_BITS + BANK_BITS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    cfg_start_addr = '0;
    logic [ADDR_W-1:0]    cfg_end_addr = '0;
    logic [COL_BITS:0]    cfg_run_len = '0;
    logic [BANK_BITS:0]   cfg_banks_used = '0;
    logic [6:0]           cfg_read_pct = '0;
    logic                 cfg_map_sel = 1'b0;
    logic                 req_valid;
    logic                 req_ready = 1'b0;
    logic [ADDR_W-1:0]    req_addr;
    logic                 req_is_read;
    logic [BURST_BITS:0]  req_bytes;
    logic [BYTE_W-1:0]    byte_count;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pagehit_gen #(
        .ADDR_W (ADDR_W), .BURST_BITS (BURST_BITS), .COL_BITS (COL_BITS),
        .BANK_BITS (BANK_BITS), .BYTE_W (BYTE_W)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_start_addr (cfg_start_addr), .cfg_end_addr (cfg_end_addr),
        .cfg_run_len (cfg_run_len), .cfg_banks_used (cfg_banks_used),
        .cfg_read_pct (cfg_read_pct), .cfg_map_sel (cfg_map_sel),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .req_is_read (req_is_read), .req_bytes (req_bytes), .byte_count (byte_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int col_of(input logic [ADDR_W-1:0] a, input logic m);
        return m ? int'(a[BURST_BITS +: COL_BITS]) : int'(a[BURST_BITS + BANK_BITS +: COL_BITS]);
    endfunction

    function automatic int bank_of(input logic [ADDR_W-1:0] a, input logic m);
        return m ? int'(a[BURST_BITS + COL_BITS +: BANK_BITS]) : int'(a[BURST_BITS +: BANK_BITS]);
    endfunction

    // Apply a configuration under reset and check the reset state (R1).
    task automatic do_reset(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                            input int len, input int banks, input int pct, input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        req_ready = 1'b0;
        cfg_start_addr = s;
        cfg_end_addr = e;
        cfg_run_len = (COL_BITS+1)'(len);
        cfg_banks_used = (BANK_BITS+1)'(banks);
        cfg_read_pct = 7'(pct);
        cfg_map_sel = m;
        repeat (3) @(negedge clk);
        check(req_valid == 1'b0, "R1 valid in reset", longint'(req_valid), 0);
        check(byte_count == '0, "R1 bytes in reset", longint'(byte_count), 0);
        rst_n = 1'b1;
    endtask

    // Accept runs back to back and check the run structure request by request.
    task automatic run_stream(input int runs, output int n_rd, output int n_wr);
        int len;
        int banks;
        logic m;
        logic [ADDR_W-1:0] hi_lo;
        logic [ADDR_W-1:0] hi_hi;
        len = (cfg_run_len == '0) ? 1 : int'(cfg_run_len);
        banks = (cfg_banks_used == '0) ? 1 : int'(cfg_banks_used);
        m = cfg_map_sel;
        hi_lo = cfg_start_addr >> HI_SHIFT;
        hi_hi = (cfg_end_addr - 1) >> HI_SHIFT;
        n_rd = 0;
        n_wr = 0;
        for (int r = 0; r < runs; r++) begin
            int first_bank;
            int prev_col;
            logic first_rd;
            logic [ADDR_W-1:0] first_hi;
            first_bank = 0; prev_col = 0; first_rd = 1'b0; first_hi = '0;
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                req_ready = 1'b1;
                check(req_valid == 1'b1, "R1 valid during stream", longint'(req_valid), 1);
                check(req_addr[BURST_BITS-1:0] == '0, "R3 burst alignment",
                      longint'(req_addr[BURST_BITS-1:0]), 0);
                check(bank_of(req_addr, m) < banks, m ? "R4/R7 bank bound" : "R4/R8 bank bound",
                      bank_of(req_addr, m), banks - 1);
                if (k == 0) begin
                    first_bank = bank_of(req_addr, m);
                    first_rd = req_is_read;
                    first_hi = req_addr >> HI_SHIFT;
                    check(col_of(req_addr, m) <= COLS - len, "R5 start column fits page",
                          col_of(req_addr, m), COLS - len);
                    check(first_hi >= hi_lo && first_hi <= hi_hi, "R3 upper bits in window",
                          longint'(first_hi), longint'(hi_lo));
                    if (req_is_read) n_rd++; else n_wr++;
                end else begin
                    check(col_of(req_addr, m) == prev_col + 1,
                          m ? "R6/R7 column step" : "R6/R8 column step",
                          col_of(req_addr, m), prev_col + 1);
                    check(bank_of(req_addr, m) == first_bank, "R6 bank held",
                          bank_of(req_addr, m), first_bank);
                    check(req_is_read == first_rd, "R2 direction held in run",
                          longint'(req_is_read), longint'(first_rd));
                    check((req_addr >> HI_SHIFT) == first_hi, "R6 upper bits held",
                          longint'(req_addr >> HI_SHIFT), longint'(first_hi));
                end
                prev_col = col_of(req_addr, m);
            end
        end
        @(negedge clk);
        req_ready = 1'b0;
        check(byte_count == BYTE_W'(runs * len * BURST), "R10 bytes after stream",
              longint'(byte_count), longint'(runs * len * BURST));
    endtask

    task automatic t_reset_state();
        do_reset(32'h0001_0000, 32'h0004_0000, 4, 4, 50, 1'b1);
        @(negedge clk);
        check(req_valid == 1'b1, "R1 valid after release", longint'(req_valid), 1);
        check(req_bytes == (BURST_BITS+1)'(BURST), "R11 burst size", longint'(req_bytes), BURST);
    endtask

    task automatic t_col_low_layout();
        int nr;
        int nw;
        do_reset(32'h0010_0000, 32'h0080_0000, 6, 6, 50, 1'b1);
        run_stream(24, nr, nw);
        check(nr > 0, "R2 mixed pct gives reads", nr, 1);
        check(nw > 0, "R2 mixed pct gives writes", nw, 1);
    endtask

    task automatic t_bank_low_layout();
        int nr;
        int nw;
        do_reset(32'h0200_0000, 32'h0300_0000, 4, 8, 30, 1'b0);
        run_stream(24, nr, nw);
        check(nr > 0 && nw > 0, "R2 mixed pct bank-low layout", nr, nw);
    endtask

    task automatic t_pct_edges();
        int nr;
        int nw;
        do_reset(32'h0000_0000, 32'h0010_0000, 3, 5, 0, 1'b0);
        run_stream(12, nr, nw);
        check(nr == 0, "R2 zero pct only writes", nr, 0);
        do_reset(32'h0000_0000, 32'h0010_0000, 3, 5, 100, 1'b1);
        run_stream(12, nr, nw);
        check(nw == 0, "R2 full pct only reads", nw, 0);
    endtask

    task automatic t_page_extremes();
        int nr;
        int nw;
        do_reset(32'h0040_0000, 32'h0050_0000, COLS, 1, 60, 1'b1);
        run_stream(3, nr, nw);
        do_reset(32'h0040_0000, 32'h0050_0000, 1, 3, 60, 1'b0);
        run_stream(20, nr, nw);
        check(nr + nw == 20, "R6 single-burst runs counted", nr + nw, 20);
    endtask

    task automatic t_backpressure();
        logic [ADDR_W-1:0] a0;
        logic r0;
        do_reset(32'h0008_0000, 32'h0009_0000, 5, 4, 50, 1'b1);
        @(negedge clk);
        a0 = req_addr;
        r0 = req_is_read;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(req_valid == 1'b1 && req_addr == a0, "R9 address held", longint'(req_addr), longint'(a0));
            check(req_is_read == r0, "R9 direction held", longint'(req_is_read), longint'(r0));
            check(byte_count == '0, "R9 bytes unchanged", longint'(byte_count), 0);
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            req_ready = 1'b1;
        end
        @(negedge clk);
        req_ready = 1'b0;
        check(byte_count == BYTE_W'(10 * BURST), "R10 bytes after ten accepts",
              longint'(byte_count), 10 * BURST);
        @(negedge clk);
        check(byte_count == BYTE_W'(10 * BURST), "R9 bytes hold when idle",
              longint'(byte_count), 10 * BURST);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_col_low_layout();
        t_bank_low_layout();
        t_pct_edges();
        t_page_extremes();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule